// File: doc/BRIEF.md
# Decoupled Instruction Prefetch Unit

This block fetches instruction longwords ahead of the execution pipeline that uses them. It keeps a fetch program counter. It issues 32-bit read requests to memory at sequential word addresses and places the data that comes back into a three-entry FIFO. A consumer drains the FIFO over a valid/ready handshake. Fetch and execution run independently, so a consumer stall does not stop fetch until the buffer is full, and a memory stall is hidden for as long as buffered words remain.

The work is split into three stages. Address generation holds the fetch counter. The fetch cycle issues the request and waits for its return. Instruction buffering holds the returned words. New requests are throttled on a credit basis: the buffered words plus every request still in flight must stay below the FIFO depth, so a returning word always has a slot. On the memory side, a request is accepted on a cycle where `memReq` and `memAck` are both high. The read data comes back in issue order, at most one word per cycle and at least one cycle after acceptance, marked by `memRdValid`.

A redirect loads a new program counter, empties the FIFO and marks every request still in flight as stale. Fetch then restarts at the new address, and the stale data is dropped as it returns.

Top module: `insn_prefetch`

## Requirements
- R1: While reset is held and in the first cycle after it, `outValid` is low, `memAddr` equals the reset program counter (0 by default), and `memReq` is high.
- R2: The address of each accepted request is 4 greater than that of the request accepted before it, unless a redirect occurred in between.
- R3: `memReq` is high only while buffered words plus in-flight requests are fewer than 3, so at most 3 requests are ever outstanding and no returned word is lost.
- R4: Returned words reach the consumer in request order, and one word is delivered on every clock where `outValid` and `outReady` are both high.
- R5: `outValid` is low whenever the FIFO is empty. There is no bypass path, so a word returned on one clock edge is offered at the output no earlier than the following cycle.
- R6: In a cycle with `redirect` high, `memReq` and `outValid` are low. On that edge the FIFO is emptied, and the next request uses `redirectPc` with bits [1:0] cleared.
- R7: Data returning for requests accepted before a redirect is discarded and never appears at the output.
- R8: While `memReq` is high and `memAck` is low, with no redirect, `memAddr` stays unchanged into the next cycle.
- R9: While `outValid` is high and `outReady` is low, with no redirect, `outValid` stays high and `outData` stays unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memReq | output | 1 | Read request to memory |
| memAddr | output | 32 | Byte address of the requested longword |
| memAck | input | 1 | Memory accepts the current request |
| memRdValid | input | 1 | A read word returns this cycle, in issue order |
| memRdData | input | 32 | Returned longword |
| redirect | input | 1 | Load a new program counter and flush |
| redirectPc | input | 32 | New fetch address |
| outValid | output | 1 | A buffered longword is offered to the consumer |
| outReady | input | 1 | Consumer takes the offered word |
| outData | output | 32 | Oldest buffered longword |

## Verification
The hardest case to reach is a redirect that arrives while several requests are still in flight under a long memory latency. Stale words then return after the redirect and must be told apart from the first words of the new stream. The bench reaches it by raising the memory latency to six cycles and redirecting mid-stream to a misaligned address. Its scoreboard expects only words of the new stream, so any stale word that leaks out is reported as a mismatch. A second hard case is a full FIFO with the credit limit engaged. The bench gets there by holding the consumer off while memory answers quickly, and then checks that requests stop, that the output holds steady, and that three words drain on consecutive clocks.

// File: rtl/prefetch_pkg.sv
`timescale 1ns/1ps
package prefetch_pkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic issue;   // request accepted by memory: advance fetch counter
    logic push;    // returned word is live: write it into the buffer
    logic pop;     // consumer takes the oldest word
    logic flush;   // redirect: load new counter, empty buffer
  } pfStrobe_t;
endpackage

// File: rtl/prefetch_ctrl.sv
`timescale 1ns/1ps
module prefetch_ctrl
  import prefetch_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      memAck,
  input  logic      memRdValid,
  input  logic      redirect,
  input  logic      outReady,
  output logic      memReq,
  output logic      outValid,
  output pfStrobe_t strobe
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W:0] DEPTH_C = DEPTH[CNT_W:0];

  logic [CNT_W-1:0] occCnt;     // words held in the buffer
  logic [CNT_W-1:0] inflight;   // accepted requests not yet returned
  logic [CNT_W-1:0] staleCnt;   // in-flight requests issued before a redirect
  logic [CNT_W:0]   committed;
  logic             issue, push, pop;

  assign committed = {1'b0, occCnt} + {1'b0, inflight};
  assign memReq    = !redirect && (committed < DEPTH_C);
  assign issue     = memReq && memAck;
  assign push      = memRdValid && (staleCnt == '0) && !redirect;
  assign outValid  = (occCnt != '0) && !redirect;
  assign pop       = outValid && outReady;

  assign strobe = '{issue: issue, push: push, pop: pop, flush: redirect};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occCnt   <= '0;
      inflight <= '0;
      staleCnt <= '0;
    end else begin
      inflight <= inflight + CNT_W'(issue) - CNT_W'(memRdValid);
      if (redirect) begin
        occCnt   <= '0;
        staleCnt <= inflight - CNT_W'(memRdValid);
      end else begin
        occCnt <= occCnt + CNT_W'(push) - CNT_W'(pop);
        if (memRdValid && (staleCnt != '0))
          staleCnt <= staleCnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/prefetch_dp.sv
`timescale 1ns/1ps
module prefetch_dp
  import prefetch_pkg::*;
#(
  parameter int          DEPTH    = 3,
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  pfStrobe_t         strobe,
  input  logic [ADDR_W-1:0] redirectPc,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] outData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] fetchPc;
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [DATA_W-1:0] slot [DEPTH];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  // Address generation stage
  always_ff @(posedge clk) begin
    if (!rstN)              fetchPc <= RESET_PC[ADDR_W-1:0];
    else if (strobe.flush)  fetchPc <= {redirectPc[ADDR_W-1:2], 2'b00};
    else if (strobe.issue)  fetchPc <= fetchPc + STEP;
  end
  assign memAddr = fetchPc;

  // Buffer pointers
  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= bump(wrPtr);
      if (strobe.pop)  rdPtr <= bump(rdPtr);
    end
  end

  // Buffer storage, one register per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.push && (wrPtr == PTR_W'(i))) slot[i] <= memRdData;
    end
  end

  assign outData = slot[rdPtr];
endmodule

// File: rtl/insn_prefetch.sv
`timescale 1ns/1ps
module insn_prefetch
  import prefetch_pkg::*;
#(
  parameter int          DEPTH    = 3,
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic              memRdValid,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] redirectPc,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData
);
  pfStrobe_t strobe;

  prefetch_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .memAck(memAck), .memRdValid(memRdValid),
    .redirect(redirect), .outReady(outReady), .memReq(memReq),
    .outValid(outValid), .strobe(strobe)
  );

  prefetch_dp #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                .RESET_PC(RESET_PC)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .redirectPc(redirectPc),
    .memRdData(memRdData), .memAddr(memAddr), .outData(outData)
  );
endmodule

// File: rtl/insn_prefetch_chk.sv
`timescale 1ns/1ps
module insn_prefetch_chk #(
  parameter int DEPTH  = 3,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAck,
  input logic              memRdValid,
  input logic              redirect,
  input logic [ADDR_W-1:0] redirectPc,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData
);
  // Outstanding requests as seen at the memory port
  logic [7:0] portInflight;
  always_ff @(posedge clk) begin
    if (!rstN) portInflight <= '0;
    else portInflight <= portInflight + 8'(memReq && memAck) - 8'(memRdValid);
  end

  a_r3_inflight_bound: assert property (@(posedge clk) disable iff (!rstN)
    portInflight <= 8'(DEPTH));

  a_r2_sequential: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && !redirect) |=> memAddr == $past(memAddr) + ADDR_W'(4));

  a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !redirect) |=> memAddr == $past(memAddr));

  a_r6_no_req: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> (!memReq && !outValid));

  a_r6_restart: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> memAddr == ($past(redirectPc) & ~ADDR_W'(3)));

  a_r5_no_bypass: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(memRdValid));

  a_r9_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !redirect) |=> (outValid && $stable(outData)));
endmodule

bind insn_prefetch insn_prefetch_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memAddr(memAddr), .memAck(memAck),
  .memRdValid(memRdValid), .redirect(redirect), .redirectPc(redirectPc),
  .outValid(outValid), .outReady(outReady), .outData(outData)
);

// File: tb/tb_insn_prefetch.sv
`timescale 1ns/1ps
module tb_insn_prefetch;
  logic        clk = 1'b0;
  logic        rstN;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memAck = 1'b0;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic        redirect;
  logic [31:0] redirectPc;
  logic        outValid;
  logic        outReady;
  logic [31:0] outData;

  always #2 clk = ~clk;  // 250 MHz

  insn_prefetch dut (
    .clk(clk), .rstN(rstN), .memReq(memReq), .memAddr(memAddr), .memAck(memAck),
    .memRdValid(memRdValid), .memRdData(memRdData), .redirect(redirect),
    .redirectPc(redirectPc), .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] wordAt(input logic [31:0] a);
    return {a[15:0] ^ 16'h3C5A, a[31:16] ^ 16'h0F0F};
  endfunction

  // Scoreboard: driver fills the expected stream, monitor pops it
  logic [31:0] expQ[$];
  logic [31:0] nextReqAddr;
  string       curTag = "R4";

  task automatic loadStream(input logic [31:0] pc);
    expQ.delete();
    for (int k = 0; k < 200; k++) expQ.push_back(wordAt((pc & ~32'h3) + 32'(4 * k)));
    nextReqAddr = pc & ~32'h3;
  endtask

  // Memory model state
  logic [31:0] pendA[$];
  int          pendDue[$];
  int          cyc = 0;
  int          memLat = 1;
  int          ackMode = 0;   // 0 always, 1 every other cycle, 2 never
  int          benchInfl = 0;
  bit          emptyWatch = 0;
  bit          heldPrev = 0;
  logic [31:0] heldData;

  always @(negedge clk) begin
    #1;
    cyc++;
    if (!rstN) begin
      memRdValid = 1'b0;
      memAck = 1'b0;
    end else begin
      memRdValid = 1'b0;
      if (pendA.size() > 0 && pendDue[0] <= cyc) begin
        memRdValid = 1'b1;
        memRdData  = wordAt(pendA.pop_front());
        void'(pendDue.pop_front());
        if (emptyWatch) begin
          // R5: word returning now must not be offered in the same cycle
          check(!outValid, "R5", "outValid with return into empty buffer", 32'(outValid), 32'h0);
          emptyWatch = 0;
        end
      end
      memAck = (ackMode == 0) ? 1'b1 : (ackMode == 1) ? cyc[0] : 1'b0;
      if (memReq && memAck) begin
        check(benchInfl < 3, "R3", "request accepted beyond credit", 32'(benchInfl), 32'd2);
        check(memAddr == nextReqAddr, "R2", "sequential request address", memAddr, nextReqAddr);
        nextReqAddr = nextReqAddr + 32'd4;
        pendA.push_back(memAddr);
        pendDue.push_back(cyc + memLat);
        benchInfl++;
      end else if (memReq && !redirect) begin
        check(memAddr == nextReqAddr, "R8", "unaccepted address held", memAddr, nextReqAddr);
      end
      if (memRdValid) benchInfl--;

      // R9 hold check against the previous cycle
      if (heldPrev && !redirect)
        check(outValid && outData == heldData, "R9", "output held while stalled", outData, heldData);
      heldPrev = outValid && !outReady && !redirect;
      heldData = outData;

      // Monitor: word consumed at the coming edge
      if (outValid && outReady && !redirect) begin
        if (expQ.size() == 0) check(1'b0, curTag, "unexpected word", outData, 32'h0);
        else begin
          logic [31:0] e;
          e = expQ.pop_front();
          check(outData == e, curTag, "delivered word", outData, e);
        end
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; redirect = 1'b0; redirectPc = '0; outReady = 1'b0;
    cycles(3);
    #1.5;
    check(!outValid, "R1", "outValid in reset", 32'(outValid), 32'h0);
    check(memAddr == 32'h0, "R1", "reset address", memAddr, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    loadStream(32'h0);
    #1.5;
    check(memReq && !outValid, "R1", "request after reset", 32'(memReq), 32'h1);

    // Streaming with fast memory and a ready consumer
    outReady = 1'b1; memLat = 1; ackMode = 0;
    cycles(40);

    // Slow memory, intermittent acceptance, irregular consumer
    memLat = 3; ackMode = 1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      outReady = (i % 3) != 0;
    end

    // Redirect with stale requests in flight
    ackMode = 0; memLat = 6; outReady = 1'b1;
    cycles(10);
    @(negedge clk);
    redirect = 1'b1; redirectPc = 32'h0000_1006;
    loadStream(32'h0000_1006);
    curTag = "R7";
    #1.5;
    check(!memReq && !outValid, "R6", "request and valid in redirect cycle",
          {31'h0, memReq | outValid}, 32'h0);
    @(negedge clk);
    redirect = 1'b0;
    check(memAddr == 32'h0000_1004, "R6", "restart address", memAddr, 32'h0000_1004);
    cycles(60);
    curTag = "R4";

    // Fill the buffer with the consumer stalled
    memLat = 2; outReady = 1'b0;
    cycles(20);
    #1.5;
    check(outValid, "R3", "buffer full offers data", 32'(outValid), 32'h1);
    check(!memReq, "R3", "no request when credits used", 32'(memReq), 32'h0);
    cycles(5);
    @(negedge clk);
    outReady = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1.5;
      check(outValid, "R4", "back-to-back delivery", 32'(outValid), 32'h1);
      @(negedge clk);
    end

    // Memory stalls; empty buffer keeps valid low
    ackMode = 2;
    cycles(15);
    @(negedge clk);
    redirect = 1'b1; redirectPc = 32'h0000_2000;
    loadStream(32'h0000_2000);
    @(negedge clk);
    redirect = 1'b0;
    for (int i = 0; i < 8; i++) begin
      #1.5;
      check(!outValid, "R5", "valid while empty", 32'(outValid), 32'h0);
      @(negedge clk);
    end
    emptyWatch = 1;
    ackMode = 0; memLat = 1;
    cycles(40);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule